// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

This block is one channel of a memory-mapped interval timer. A free-running prescaler divides the bus clock into a slow counting rate. While the channel's run bit is set, an up-counter advances once per slow tick. When the counter equals the compare register, the next count takes it back to zero instead, and a sticky match flag is set. The match flag and an interrupt-enable bit together drive a level interrupt. That interrupt stays asserted until software clears the flag by writing 0 to it.

The channel is built in one of two variants, selected by `CNT_W` (16 or 32). The variant sets the counter and compare widths, the register stride, the position of the match flag, and whether a second full-scale flag exists. A run/stop register sits at byte offset 0. The channel's own control/status, count and compare registers start at `CH_BASE`.

Software writes to the counter do not take effect at once. They are staged and land on the second slow tick after the write, so the slow-clock timing is preserved even though all logic runs on one clock.

Top module: `cmt_timer_ch`

## Requirements
- R1: The compare register resets to all ones (0xFFFF or 0xFFFFFFFF) and changes only when it is written, at `CH_BASE + 2*stride`.
- R2: Bit `START_BIT` of the register at offset 0 runs the counter when 1. When it is 0, the counter holds its value.
- R3: Control bits 1:0 select the slow tick rate as one count per 8, 32, 128 or 512 clocks (codes 0, 1, 2, 3). The prescaler runs whether or not the channel is started.
- R4: A counter write at `CH_BASE + stride` becomes visible only on the second slow tick after the write. Reads before that return the old value.
- R5: When the counter equals the compare value, the next count loads zero and sets the match flag (bit 7 in the 16-bit variant, bit 15 in the 32-bit variant), giving a period of compare+1 counts.
- R6: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A flag set by hardware wins over a clear in the same cycle.
- R7: Control bit 6 enables the interrupt, and `irq_o` is high exactly while the match flag and the enable are both 1. Writing 0 to the control register drops `irq_o` on the next cycle.
- R8: In the 32-bit variant, control bit 14 is a sticky full-scale flag, set when a count advances the counter from all ones.
- R9: When an applied counter write and a count fall on the same tick, the written value is loaded; no increment, wrap or flag occurs.
- R10: Register stride is 2 bytes in the 16-bit variant and 4 bytes in the 32-bit variant. Offsets between registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data, valid in the same cycle as the read |
| irq_o | output | 1 | Match interrupt, level |

## Verification
A wrong prescale mask or run gate first shows as a counter read that drifts from the reference within one slow tick, which is at most 512 clocks. A misplaced flag update shows on `irq_o` within the same cycle it happens, because the interrupt is compared against the model on every clock. Staging faults in the counter write path, such as landing a tick early or late or losing to a simultaneous count, appear as a counter read mismatch during the few cycles around the tick. Those ticks are swept across every phase of the prescaler.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  typedef enum logic [1:0] {DIV8 = 2'd0, DIV32 = 2'd1, DIV128 = 2'd2, DIV512 = 2'd3} cmt_div_e;

  localparam int PRE_W   = 9;
  localparam int IDX_CSR = 0;
  localparam int IDX_CNT = 1;
  localparam int IDX_CMP = 2;
  localparam int IE_BIT  = 6;
  localparam int FF_BIT  = 14;

  function automatic logic [PRE_W-1:0] div_mask(cmt_div_e d);
    case (d)
      DIV8:    return 9'h007;
      DIV32:   return 9'h01f;
      DIV128:  return 9'h07f;
      default: return 9'h1ff;
    endcase
  endfunction

  function automatic int stride_of(int w);
    return (w == 32) ? 4 : 2;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmt_div_e div_i,
  output logic     tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign mask   = div_mask(div_i);
  assign tick_o = ((pre_q & mask) == mask);
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic [1:0]   stage_o,
  output logic         match_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q, pend_q;
  logic [1:0]   stage_q;
  logic         apply, step, hit;

  assign apply = tick_i && (stage_q == 2'd1);
  assign step  = tick_i && run_i && !apply;
  assign hit   = (cnt_q == cmp_i);

  // staged write: lands on the second slow tick after the bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      stage_q <= 2'd0;
    end else if (wr_i) begin
      pend_q  <= wdata_i;
      stage_q <= 2'd2;
    end else if (tick_i && stage_q != 2'd0) begin
      stage_q <= stage_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (apply) cnt_q <= pend_q;
    else if (step)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign stage_o = stage_q;
  assign match_o = step && hit;
  assign full_o  = step && (&cnt_q);
endmodule

// File: rtl/cmt_ctrl.sv
`timescale 1ns/1ps
module cmt_ctrl
  import cmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        wr_mf_i,
  input  logic        wr_ff_i,
  input  logic        wr_ie_i,
  input  logic [1:0]  wr_div_i,
  input  logic        match_i,
  input  logic        full_i,
  output logic        mf_o,
  output logic        ff_o,
  output logic        ie_o,
  output cmt_div_e    div_o,
  output logic [15:0] csr_o
);
  localparam int  MF_BIT   = (W == 32) ? 15 : 7;
  localparam bit  HAS_FULL = (W == 32);

  logic     mf_q, ff_q, ie_q;
  cmt_div_e div_q;
  logic     full_set;

  assign full_set = HAS_FULL ? full_i : 1'b0;

  // hardware set has priority over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mf_q  <= 1'b0;
      ff_q  <= 1'b0;
      ie_q  <= 1'b0;
      div_q <= DIV8;
    end else begin
      mf_q <= match_i  | (mf_q & (wr_i ? wr_mf_i : 1'b1));
      ff_q <= full_set | (ff_q & (wr_i ? wr_ff_i : 1'b1));
      if (wr_i) begin
        ie_q  <= wr_ie_i;
        div_q <= cmt_div_e'(wr_div_i);
      end
    end
  end

  always_comb begin
    csr_o         = '0;
    csr_o[1:0]    = div_q;
    csr_o[IE_BIT] = ie_q;
    csr_o[MF_BIT] = mf_q;
    if (HAS_FULL) csr_o[FF_BIT] = ff_q;
  end

  assign mf_o  = mf_q;
  assign ff_o  = ff_q;
  assign ie_o  = ie_q;
  assign div_o = div_q;
endmodule

// File: rtl/cmt_timer_ch.sv
`timescale 1ns/1ps
module cmt_timer_ch
  import cmt_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          AW        = 8,
  parameter logic [7:0]  CH_BASE   = 8'h10,
  parameter int          START_BIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int          STRIDE     = stride_of(CNT_W);
  localparam int          MF_BIT     = (CNT_W == 32) ? 15 : 7;
  localparam logic [AW-1:0] START_ADDR = '0;
  localparam logic [AW-1:0] CSR_ADDR   = AW'(CH_BASE + IDX_CSR * STRIDE);
  localparam logic [AW-1:0] CNT_ADDR   = AW'(CH_BASE + IDX_CNT * STRIDE);
  localparam logic [AW-1:0] CMP_ADDR   = AW'(CH_BASE + IDX_CMP * STRIDE);

  logic             wr_start, wr_csr, wr_cnt, wr_cmp;
  logic             run_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic [1:0]       pend_stage;
  logic             tick, match, full;
  logic             mf_q, ff_q, ie_q;
  cmt_div_e         div;
  logic [15:0]      csr;

  assign wr_start = sel_i && we_i && (addr_i == START_ADDR);
  assign wr_csr   = sel_i && we_i && (addr_i == CSR_ADDR);
  assign wr_cnt   = sel_i && we_i && (addr_i == CNT_ADDR);
  assign wr_cmp   = sel_i && we_i && (addr_i == CMP_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cmp_q <= '1;
    end else begin
      if (wr_start) run_q <= wdata_i[START_BIT];
      if (wr_cmp)   cmp_q <= wdata_i;
    end
  end

  cmt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div),
    .tick_o (tick)
  );

  cmt_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .run_i   (run_q),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt_q),
    .stage_o (pend_stage),
    .match_o (match),
    .full_o  (full)
  );

  cmt_ctrl #(.W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_csr),
    .wr_mf_i  (wdata_i[MF_BIT]),
    .wr_ff_i  (wdata_i[FF_BIT % CNT_W]),
    .wr_ie_i  (wdata_i[IE_BIT]),
    .wr_div_i (wdata_i[1:0]),
    .match_i  (match),
    .full_i   (full),
    .mf_o     (mf_q),
    .ff_o     (ff_q),
    .ie_o     (ie_q),
    .div_o    (div),
    .csr_o    (csr)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      if (addr_i == START_ADDR)    rdata_o[START_BIT] = run_q;
      else if (addr_i == CSR_ADDR) rdata_o[15:0]      = csr;
      else if (addr_i == CNT_ADDR) rdata_o            = cnt_q;
      else if (addr_i == CMP_ADDR) rdata_o            = cmp_q;
    end
  end

  assign irq_o = mf_q && ie_q;
endmodule

// File: rtl/cmt_timer_ch_chk.sv
`timescale 1ns/1ps
module cmt_timer_ch_chk #(
  parameter int         CNT_W   = 16,
  parameter int         AW      = 8,
  parameter logic [7:0] CH_BASE = 8'h10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic             ie_bit_i,
  input logic             irq_o,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             mf_q,
  input logic             ff_q,
  input logic             tick,
  input logic [1:0]       pend_stage
);
  localparam int            STRIDE   = (CNT_W == 32) ? 4 : 2;
  localparam logic [AW-1:0] CSR_ADDR = AW'(CH_BASE);
  localparam logic [AW-1:0] CNT_ADDR = AW'(CH_BASE + STRIDE);
  localparam logic [AW-1:0] CMP_ADDR = AW'(CH_BASE + 2 * STRIDE);

  a_r1_cmp_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i && addr_i == CMP_ADDR) |=> $stable(cmp_q));

  a_r2_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && pend_stage == 2'd0) |=> $stable(cnt_q));

  a_r3_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));

  a_r4_write_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == CNT_ADDR) |=> (pend_stage == 2'd2));

  a_r5_flag_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mf_q) |-> (cnt_q == '0));

  a_r5_flag_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mf_q) |-> $past(run_q));

  a_r7_zero_ie_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == CSR_ADDR && !ie_bit_i) |=> !irq_o);

  a_r8_full_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ff_q) |-> (cnt_q == '0));
endmodule

bind cmt_timer_ch cmt_timer_ch_chk #(.CNT_W(CNT_W), .AW(AW), .CH_BASE(CH_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .ie_bit_i   (wdata_i[6]),
  .irq_o      (irq_o),
  .run_q      (run_q),
  .cnt_q      (cnt_q),
  .cmp_q      (cmp_q),
  .mf_q       (mf_q),
  .ff_q       (ff_q),
  .tick       (tick),
  .pend_stage (pend_stage)
);

// File: tb/sim_cmt_timer_ch.sv
`timescale 1ns/1ps
module sim_cmt_timer_ch;
  localparam int W = 32;
  localparam logic [7:0] A_START = 8'h00, A_CSR = 8'h10, A_CNT = 8'h14, A_CMP = 8'h18;

  logic         clk_i = 1'b0, rst_ni = 1'b0, sel_i = 1'b0, we_i = 1'b0;
  logic [7:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         irq_o;

  always #5 clk_i = ~clk_i;

  cmt_timer_ch #(.CNT_W(32), .AW(8), .CH_BASE(8'h10), .START_BIT(0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  int  checks = 0, errors = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference model
  int           m_pre, m_div, m_stage;
  logic         m_run, m_ie, m_mf, m_ff;
  logic [W-1:0] m_cnt, m_cmp, m_pv;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_div = 0; m_stage = 0;
      m_run = 0; m_ie = 0; m_mf = 0; m_ff = 0;
      m_cnt = '0; m_cmp = '1; m_pv = '0;
    end else begin
      int   mask;
      bit   tk, ap, st, hit, ms, fs;
      logic [W-1:0] n_cnt;
      mask  = (8 << (2 * m_div)) - 1;
      tk    = ((m_pre & mask) == mask);
      ap    = tk && (m_stage == 1);
      st    = tk && m_run && !ap;
      hit   = (m_cnt == m_cmp);
      ms    = st && hit;
      fs    = st && (m_cnt == 32'hffff_ffff);
      n_cnt = ap ? m_pv : (st ? (hit ? '0 : m_cnt + 1) : m_cnt);
      if (sel_i && we_i && addr_i == A_CNT) begin
        m_pv = wdata_i; m_stage = 2;
      end else if (tk && m_stage != 0) m_stage = m_stage - 1;
      if (sel_i && we_i && addr_i == A_CSR) begin
        m_mf  = ms | (m_mf & wdata_i[15]);
        m_ff  = fs | (m_ff & wdata_i[14]);
        m_ie  = wdata_i[6];
        m_div = int'(wdata_i[1:0]);
      end else begin
        m_mf = m_mf | ms;
        m_ff = m_ff | fs;
      end
      if (sel_i && we_i && addr_i == A_START) m_run = wdata_i[0];
      if (sel_i && we_i && addr_i == A_CMP)   m_cmp = wdata_i;
      m_cnt = n_cnt;
      m_pre = (m_pre + 1) % 512;
    end
  end

  always @(posedge clk_i) cyc++;

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    #3;
    if (rst_ni && !done) begin
      chk("R7 irq vs model", {31'b0, irq_o}, {31'b0, m_mf & m_ie});
      if (sel_i && !we_i) begin
        case (addr_i)
          A_START: chk("R2 run reg vs model", rdata_o, {31'b0, m_run});
          A_CSR:   chk("R6 csr vs model", rdata_o,
                       {16'b0, m_mf, m_ff, 7'b0, m_ie, 4'b0, 2'(m_div)});
          A_CNT:   chk("R4 count vs model", rdata_o, m_cnt);
          A_CMP:   chk("R1 compare vs model", rdata_o, m_cmp);
          default: chk("R10 gap reads zero", rdata_o, '0);
        endcase
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] v);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #3 v = rdata_o;
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
    repeat (n - 1) @(negedge clk_i);
  endtask

  task automatic wait_irq(output int c);
    c = -1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      #3;
      if (irq_o) begin c = cyc; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [W-1:0] v, v2;
    int c0, c1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    rd(A_CMP, v);   chk("R1 compare reset", v, 32'hffff_ffff);
    rd(A_CSR, v);   chk("R7 csr reset", v, '0);
    rd(A_CNT, v);   chk("R2 count reset", v, '0);
    rd(A_START, v); chk("R2 run reset", v, '0);
    chk("R7 irq reset", {31'b0, irq_o}, '0);

    // stride: 4 bytes, gaps read zero
    wr(A_CMP, 32'd3);
    rd(A_CMP, v);   chk("R10 compare at base+8", v, 32'd3);
    rd(8'h12, v);   chk("R10 half-stride gap", v, '0);

    // staged counter write
    wr(A_CNT, 32'd5);
    rd(A_CNT, v);   chk("R4 old value before two ticks", v, '0);
    idle(30);
    rd(A_CNT, v);   chk("R4 value after two ticks", v, 32'd5);

    // stopped counter holds
    idle(50);
    rd(A_CNT, v);   chk("R2 held while stopped", v, 32'd5);

    // match, flag, interrupt
    wr(A_CNT, 32'd0);
    idle(30);
    wr(A_CSR, 32'h0040);
    wr(A_START, 32'd1);
    idle(40);
    rd(A_CSR, v);   chk("R5 match flag bit15", v & 32'h8040, 32'h8040);
    chk("R7 irq with flag and enable", {31'b0, irq_o}, 32'd1);

    wr(A_START, 32'd0);
    wr(A_CSR, 32'hC040);
    rd(A_CSR, v);   chk("R6 write 1 keeps flag", v & 32'h8000, 32'h8000);
    wr(A_CSR, 32'h0040);
    rd(A_CSR, v);   chk("R6 write 0 clears flag", v & 32'h8000, '0);
    chk("R7 irq drops on clear", {31'b0, irq_o}, '0);

    // period = compare + 1 counts of 8 clocks
    wr(A_START, 32'd1);
    wait_irq(c0);
    wr(A_CSR, 32'h0040);
    wait_irq(c1);
    chk("R5 period (cmp+1)*8", 32'(c1 - c0), 32'd32);

    // zero to csr masks interrupt; flag still sets
    wr(A_CSR, 32'h0);
    idle(40);
    chk("R7 irq masked after zero write", {31'b0, irq_o}, '0);
    rd(A_CSR, v);   chk("R7 flag still sets when masked", v & 32'h8000, 32'h8000);

    // set vs clear collision sweep
    wr(A_CMP, 32'd1);
    for (int i = 0; i < 40; i++) wr(A_CSR, 32'h0040);
    rd(A_CSR, v);

    // prescale rates
    wr(A_CMP, 32'hffff_ffff);
    rd(A_CNT, v);  idle(64);
    rd(A_CNT, v2); chk("R3 div8: 8 counts in 64 clocks", v2 - v, 32'd8);
    wr(A_CSR, 32'h0003);
    idle(1100);
    rd(A_CNT, v);  idle(512);
    rd(A_CNT, v2); chk("R3 div512: 1 count in 512 clocks", v2 - v, 32'd1);
    wr(A_CSR, 32'h0001);
    idle(100);
    rd(A_CNT, v);  idle(128);
    rd(A_CNT, v2); chk("R3 div32: 4 counts in 128 clocks", v2 - v, 32'd4);

    // full-scale flag
    wr(A_START, 32'd0);
    wr(A_CSR, 32'h0);
    wr(A_CNT, 32'hffff_fffe);
    idle(30);
    rd(A_CSR, v);  chk("R8 full flag clear before", v & 32'h4000, '0);
    wr(A_START, 32'd1);
    idle(40);
    rd(A_CSR, v);  chk("R8 full and match flags set", v & 32'hC000, 32'hC000);

    // write vs count collision at every prescaler phase
    for (int ph = 0; ph < 8; ph++) begin
      idle(ph + 1);
      wr(A_CNT, 32'(1000 * (ph + 1)));
      idle(30);
      rd(A_CNT, v);
      chk("R9 written value loaded",
          {31'b0, (v >= 32'(1000 * (ph + 1))) && (v < 32'(1000 * (ph + 1) + 5))}, 32'd1);
    end

    idle(5);
    finish_run();
  end
endmodule